// File: doc/BRIEF.md
# Instruction Fetch Miss Buffers

This block sits between an instruction cache and the external memory bus and handles instruction fetches that miss. The fetch unit presents a lookup address together with the cache's own hit result for that cycle. The block searches its two line buffers at the same time. If neither a buffer nor the cache holds the line, the block claims a free buffer and issues one request for the whole 32-byte line. The request carries a tag that names the buffer.

Words come back tagged with their buffer, in order from word 0, at most one per cycle. Each word is stored and its valid bit is set. The word the fetch unit asked for goes to the decoder in the cycle it arrives, without waiting for the rest of the line. A lookup to a line that is already pending reuses that buffer: it hits at once if its word has arrived, and otherwise waits for that word. When all eight words are in, the line is offered to the cache for one cycle, but only if it was marked cacheable and the cache is enabled. The buffer is then cleared and becomes free. While both buffers are busy, a new miss stalls the fetch unit.

Top module: `ifetch_miss_unit`

## Requirements
- R1: After reset both buffers are free, and `lk_ready_o`, `dec_valid_o`, `breq_valid_o` and `fill_valid_o` are low while no lookup is presented.
- R2: A lookup for a line that no busy buffer holds, with `cache_hit_i` high, completes in the same cycle (`lk_ready_o` high). It issues no bus request and drives no decoder word. A lookup that neither the buffers nor the cache hold is a miss, and `lk_ready_o` stays low.
- R3: A miss claims the lowest-numbered free buffer. `breq_tag_o` carries that buffer's index (0 or 1), and the index of a buffer that has become free again is reused.
- R4: A miss raises `breq_valid_o` for one cycle, in the cycle the miss is presented, with `breq_addr_o` equal to the lookup address with its low 5 bits cleared.
- R5: Each returned word is stored in the buffer named by `bret_tag_i`, at the next word position (0 to 7). Words of two buffers may be interleaved and each line still fills correctly.
- R6: When the word a pending lookup waits for arrives, `dec_valid_o` and `lk_ready_o` are high in that same cycle, and `dec_word_o` equals `bret_data_i`.
- R7: A lookup whose line is pending in a buffer issues no new request. If its word has already arrived, the lookup hits in the same cycle and returns the stored word.
- R8: In the cycle after the eighth word arrives, `fill_valid_o` is high, provided the line was cacheable at the miss and `cache_en_i` is high. `fill_addr_o` is then the line address, and word i of `fill_line_o` sits at bits [32i+31:32i].
- R9: After that cycle the buffer is free and all of its valid bits are clear. A later lookup to the same line, with no cache hit, misses and issues a new request.
- R10: While both buffers are busy, a miss holds `lk_ready_o` low and issues no request. It proceeds in the first cycle in which a buffer is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup presented, held until `lk_ready_o` |
| lk_addr_i | input | 32 | Byte address of the instruction |
| lk_cacheable_i | input | 1 | Line may be written to the cache |
| cache_hit_i | input | 1 | Cache array hit for this lookup |
| cache_en_i | input | 1 | Instruction cache enabled |
| lk_ready_o | output | 1 | Lookup completes this cycle |
| dec_valid_o | output | 1 | Word for the decoder supplied by this block |
| dec_word_o | output | 32 | Instruction word to the decoder |
| breq_valid_o | output | 1 | Line request to the bus |
| breq_addr_o | output | 32 | Line-aligned request address |
| breq_tag_o | output | 1 | Buffer index carried by the request |
| bret_valid_i | input | 1 | Returned word present |
| bret_tag_i | input | 1 | Buffer the returned word belongs to |
| bret_data_i | input | 32 | Returned word |
| fill_valid_o | output | 1 | Completed line offered to the cache |
| fill_addr_o | output | 32 | Line-aligned address of the fill |
| fill_line_o | output | 256 | Line data, word 0 in the low bits |

## Verification
The requested word is placed at the start, in the middle and at the end of a line. This separates forwarding in the arrival cycle from forwarding after the line is complete, and a hit on a stored word from a wait for a missing one. Two lines are filled with their words interleaved by tag, so that a slip in buffer selection or word position shows up in the filled data. A third miss is held against two busy buffers, which shows whether the stall lasts through the completion cycle and whether the freed index is reused. Lines that are not cacheable, or filled while the cache is disabled, are followed by a lookup to the same line; this shows that the buffer's valid bits were cleared rather than left to hit.

// File: rtl/ifm_pkg.sv
package ifm_pkg;
  localparam int IFM_NUM_BUF    = 2;
  localparam int IFM_LINE_WORDS = 8;
  localparam int IFM_WORD_W     = 32;
  localparam int IFM_ADDR_W     = 32;

  typedef enum logic [1:0] {
    BS_FREE = 2'd0,
    BS_FILL = 2'd1,
    BS_DONE = 2'd2
  } fbuf_state_e;
endpackage

// File: rtl/ifm_fetch_buf.sv
module ifm_fetch_buf
  import ifm_pkg::*;
#(
  parameter int LINE_WORDS = IFM_LINE_WORDS,
  parameter int WORD_W     = IFM_WORD_W,
  parameter int LTAG_W     = 27
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_i,
  input  logic [LTAG_W-1:0]            alloc_line_i,
  input  logic                         alloc_cach_i,
  input  logic                         ret_i,
  input  logic [WORD_W-1:0]            ret_data_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         cach_o,
  output logic [LTAG_W-1:0]            line_o,
  output logic [LINE_WORDS-1:0]        vld_o,
  output logic [$clog2(LINE_WORDS)-1:0] next_idx_o,
  output logic [LINE_WORDS*WORD_W-1:0] data_o
);
  localparam int IDX_W = $clog2(LINE_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

  fbuf_state_e       state;
  logic [IDX_W-1:0]  wptr;
  logic [WORD_W-1:0] mem [LINE_WORDS];
  logic              take_word;
  logic              last_word;

  assign take_word = ret_i && (state == BS_FILL);
  assign last_word = take_word && (wptr == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= BS_FREE;
      wptr   <= '0;
      vld_o  <= '0;
      line_o <= '0;
      cach_o <= 1'b0;
    end else begin
      case (state)
        BS_FREE: begin
          if (alloc_i) begin
            state  <= BS_FILL;
            line_o <= alloc_line_i;
            cach_o <= alloc_cach_i;
            vld_o  <= '0;
            wptr   <= '0;
          end
        end
        BS_FILL: begin
          if (take_word) begin
            vld_o[wptr] <= 1'b1;
            wptr        <= wptr + 1'b1;
            if (last_word) state <= BS_DONE;
          end
        end
        BS_DONE: begin
          state <= BS_FREE;
          vld_o <= '0;
        end
        default: state <= BS_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_word) mem[wptr] <= ret_data_i;
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_pack
    assign data_o[w*WORD_W +: WORD_W] = mem[w];
  end

  assign busy_o     = (state != BS_FREE);
  assign done_o     = (state == BS_DONE);
  assign next_idx_o = wptr;

  p_ret_while_filling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> (state == BS_FILL));
  p_valid_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_word |=> ($countones(vld_o) == $countones($past(vld_o)) + 1));
  p_free_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && (vld_o == '0)));
  p_alloc_only_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !busy_o);
endmodule

// File: rtl/ifm_alloc.sv
module ifm_alloc #(
  parameter int NUM_BUF = 2,
  parameter int TAG_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_i,
  input  logic [NUM_BUF-1:0] busy_i,
  output logic [NUM_BUF-1:0] alloc_o,
  output logic [TAG_W-1:0]   idx_o,
  output logic               any_free_o
);
  function automatic logic [TAG_W-1:0] first_free(input logic [NUM_BUF-1:0] busy);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (!busy[b]) r = TAG_W'(b);
    end
    return r;
  endfunction

  assign any_free_o = !(&busy_i);
  assign idx_o      = first_free(busy_i);

  always_comb begin
    alloc_o = '0;
    if (miss_i && any_free_o) alloc_o[idx_o] = 1'b1;
  end

  p_alloc_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_o));
  p_alloc_to_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((alloc_o & busy_i) == '0));
endmodule

// File: rtl/ifm_hit_fwd.sv
module ifm_hit_fwd #(
  parameter int NUM_BUF    = 2,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32,
  parameter int LTAG_W     = 27,
  parameter int TAG_W      = 1
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [LTAG_W-1:0]                         lk_line_i,
  input  logic [$clog2(LINE_WORDS)-1:0]             lk_widx_i,
  input  logic [NUM_BUF-1:0]                        busy_i,
  input  logic [NUM_BUF-1:0][LTAG_W-1:0]            lines_i,
  input  logic [NUM_BUF-1:0][LINE_WORDS-1:0]        vlds_i,
  input  logic [NUM_BUF-1:0][$clog2(LINE_WORDS)-1:0] nidx_i,
  input  logic [NUM_BUF-1:0][LINE_WORDS*WORD_W-1:0] datas_i,
  input  logic                                      ret_valid_i,
  input  logic [TAG_W-1:0]                          ret_tag_i,
  input  logic [WORD_W-1:0]                         ret_data_i,
  output logic                                      match_any_o,
  output logic                                      hit_o,
  output logic                                      arrive_o,
  output logic [WORD_W-1:0]                         word_o
);
  localparam int IDX_W = $clog2(LINE_WORDS);

  function automatic logic [WORD_W-1:0] pick_word(
    input logic [LINE_WORDS*WORD_W-1:0] line, input logic [IDX_W-1:0] idx);
    return line[idx*WORD_W +: WORD_W];
  endfunction

  logic [NUM_BUF-1:0] match;

  always_comb begin
    match       = '0;
    match_any_o = 1'b0;
    hit_o       = 1'b0;
    arrive_o    = 1'b0;
    word_o      = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      match[b] = busy_i[b] && (lines_i[b] == lk_line_i);
      if (match[b]) match_any_o = 1'b1;
      if (match[b] && vlds_i[b][lk_widx_i]) begin
        hit_o  = 1'b1;
        word_o = pick_word(datas_i[b], lk_widx_i);
      end
    end
    for (int b = 0; b < NUM_BUF; b++) begin
      if (ret_valid_i && (ret_tag_i == TAG_W'(b)) && match[b] &&
          !vlds_i[b][lk_widx_i] && (nidx_i[b] == lk_widx_i)) begin
        arrive_o = 1'b1;
        word_o   = ret_data_i;
      end
    end
  end

  p_hit_arrive_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && arrive_o));
  p_line_in_one_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/ifetch_miss_unit.sv
module ifetch_miss_unit
  import ifm_pkg::*;
#(
  parameter int NUM_BUF    = IFM_NUM_BUF,
  parameter int LINE_WORDS = IFM_LINE_WORDS,
  parameter int WORD_W     = IFM_WORD_W,
  parameter int ADDR_W     = IFM_ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_valid_i,
  input  logic [ADDR_W-1:0]            lk_addr_i,
  input  logic                         lk_cacheable_i,
  input  logic                         cache_hit_i,
  input  logic                         cache_en_i,
  output logic                         lk_ready_o,
  output logic                         dec_valid_o,
  output logic [WORD_W-1:0]            dec_word_o,
  output logic                         breq_valid_o,
  output logic [ADDR_W-1:0]            breq_addr_o,
  output logic [(NUM_BUF > 1 ? $clog2(NUM_BUF) : 1)-1:0] breq_tag_o,
  input  logic                         bret_valid_i,
  input  logic [(NUM_BUF > 1 ? $clog2(NUM_BUF) : 1)-1:0] bret_tag_i,
  input  logic [WORD_W-1:0]            bret_data_i,
  output logic                         fill_valid_o,
  output logic [ADDR_W-1:0]            fill_addr_o,
  output logic [LINE_WORDS*WORD_W-1:0] fill_line_o
);
  localparam int BYTE_LG = $clog2(WORD_W / 8);
  localparam int IDX_W   = $clog2(LINE_WORDS);
  localparam int OFF_W   = BYTE_LG + IDX_W;
  localparam int LTAG_W  = ADDR_W - OFF_W;
  localparam int TAG_W   = NUM_BUF > 1 ? $clog2(NUM_BUF) : 1;
  localparam int LINE_W  = LINE_WORDS * WORD_W;

  function automatic logic [LTAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [IDX_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:BYTE_LG];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [LTAG_W-1:0] t);
    return {t, {OFF_W{1'b0}}};
  endfunction

  logic [NUM_BUF-1:0]                 busy, done, cach, alloc;
  logic [NUM_BUF-1:0][LTAG_W-1:0]     lines;
  logic [NUM_BUF-1:0][LINE_WORDS-1:0] vlds;
  logic [NUM_BUF-1:0][IDX_W-1:0]      nidx;
  logic [NUM_BUF-1:0][LINE_W-1:0]     datas;

  logic [LTAG_W-1:0] lk_tag;
  logic [IDX_W-1:0]  lk_widx;
  logic              match_any, buf_hit, arrive, miss, any_free;
  logic [TAG_W-1:0]  grant;
  logic [WORD_W-1:0] fwd_word;
  logic              done_any, done_cach;
  logic [LTAG_W-1:0] done_line;
  logic [LINE_W-1:0] done_data;

  assign lk_tag  = line_tag(lk_addr_i);
  assign lk_widx = word_sel(lk_addr_i);
  assign miss    = lk_valid_i && !cache_hit_i && !match_any;

  ifm_alloc #(.NUM_BUF(NUM_BUF), .TAG_W(TAG_W)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_i     (miss),
    .busy_i     (busy),
    .alloc_o    (alloc),
    .idx_o      (grant),
    .any_free_o (any_free)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    ifm_fetch_buf #(
      .LINE_WORDS (LINE_WORDS),
      .WORD_W     (WORD_W),
      .LTAG_W     (LTAG_W)
    ) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc[g]),
      .alloc_line_i (lk_tag),
      .alloc_cach_i (lk_cacheable_i),
      .ret_i        (bret_valid_i && (bret_tag_i == TAG_W'(g))),
      .ret_data_i   (bret_data_i),
      .busy_o       (busy[g]),
      .done_o       (done[g]),
      .cach_o       (cach[g]),
      .line_o       (lines[g]),
      .vld_o        (vlds[g]),
      .next_idx_o   (nidx[g]),
      .data_o       (datas[g])
    );
  end

  ifm_hit_fwd #(
    .NUM_BUF    (NUM_BUF),
    .LINE_WORDS (LINE_WORDS),
    .WORD_W     (WORD_W),
    .LTAG_W     (LTAG_W),
    .TAG_W      (TAG_W)
  ) u_fwd (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_line_i   (lk_tag),
    .lk_widx_i   (lk_widx),
    .busy_i      (busy),
    .lines_i     (lines),
    .vlds_i      (vlds),
    .nidx_i      (nidx),
    .datas_i     (datas),
    .ret_valid_i (bret_valid_i),
    .ret_tag_i   (bret_tag_i),
    .ret_data_i  (bret_data_i),
    .match_any_o (match_any),
    .hit_o       (buf_hit),
    .arrive_o    (arrive),
    .word_o      (fwd_word)
  );

  assign dec_valid_o  = lk_valid_i && (buf_hit || arrive);
  assign dec_word_o   = fwd_word;
  assign lk_ready_o   = lk_valid_i && (buf_hit || arrive || (cache_hit_i && !match_any));
  assign breq_valid_o = |alloc;
  assign breq_addr_o  = line_addr(lk_tag);
  assign breq_tag_o   = grant;

  always_comb begin
    done_any  = 1'b0;
    done_cach = 1'b0;
    done_line = '0;
    done_data = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (done[b]) begin
        done_any  = 1'b1;
        done_cach = cach[b];
        done_line = lines[b];
        done_data = datas[b];
      end
    end
  end

  assign fill_valid_o = done_any && done_cach && cache_en_i;
  assign fill_addr_o  = line_addr(done_line);
  assign fill_line_o  = done_data;

  p_req_only_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid_o |-> (lk_valid_i && !cache_hit_i && !match_any));
  p_req_needs_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid_o |-> any_free);
  p_req_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid_o |-> (word_sel(breq_addr_o) == '0));
  p_fwd_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> lk_ready_o);
  p_pending_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && match_any) |-> !breq_valid_o);
  p_fill_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> cache_en_i);
  p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  p_stall_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && !cache_hit_i && !match_any && (&busy)) |-> (!lk_ready_o && !breq_valid_o));
endmodule

// File: tb/ifetch_miss_unit_bench.sv
`timescale 1ns/1ps
module ifetch_miss_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         lk_valid, lk_cach, cache_hit, cache_en;
  logic [31:0]  lk_addr;
  logic         lk_ready, dec_valid, breq_valid, fill_valid;
  logic [31:0]  dec_word, breq_addr, fill_addr;
  logic [0:0]   breq_tag, bret_tag;
  logic         bret_valid;
  logic [31:0]  bret_data;
  logic [255:0] fill_line;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  ifetch_miss_unit u_ifetch_miss_unit (
    .clk (clk), .rst_n (rst_n),
    .lk_valid_i (lk_valid), .lk_addr_i (lk_addr), .lk_cacheable_i (lk_cach),
    .cache_hit_i (cache_hit), .cache_en_i (cache_en),
    .lk_ready_o (lk_ready), .dec_valid_o (dec_valid), .dec_word_o (dec_word),
    .breq_valid_o (breq_valid), .breq_addr_o (breq_addr), .breq_tag_o (breq_tag),
    .bret_valid_i (bret_valid), .bret_tag_i (bret_tag), .bret_data_i (bret_data),
    .fill_valid_o (fill_valid), .fill_addr_o (fill_addr), .fill_line_o (fill_line)
  );

  function automatic logic [31:0] wdat(input logic [31:0] base, input int i);
    return base + 32'(i) * 32'h0101_0101;
  endfunction

  function automatic logic [255:0] exp_line(input logic [31:0] base);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = wdat(base, i);
    return l;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic look(input logic v, input logic [31:0] a, input logic c, input logic h);
    lk_valid = v; lk_addr = a; lk_cach = c; cache_hit = h;
  endtask

  task automatic ret(input logic v, input logic t, input logic [31:0] d);
    bret_valid = v; bret_tag = t; bret_data = d;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic t_reset();
    look(0, 32'h0, 0, 0); ret(0, 0, 0); #1;
    chk("R1", "lk_ready", 256'(lk_ready), 0);
    chk("R1", "dec_valid", 256'(dec_valid), 0);
    chk("R1", "breq_valid", 256'(breq_valid), 0);
    chk("R1", "fill_valid", 256'(fill_valid), 0);
    tick();
  endtask

  task automatic t_cache_hit();
    look(1, 32'h2000_0008, 1, 1); #1;
    chk("R2", "ready on cache hit", 256'(lk_ready), 1);
    chk("R2", "no request on cache hit", 256'(breq_valid), 0);
    chk("R2", "no decoder word on cache hit", 256'(dec_valid), 0);
    tick();
    look(0, 0, 0, 0);
  endtask

  task automatic t_miss_forward();
    logic [31:0] b = 32'hA000_0000;
    look(1, 32'h1000_0014, 1, 0); #1;
    chk("R4", "request on miss", 256'(breq_valid), 1);
    chk("R4", "line address", 256'(breq_addr), 256'(32'h1000_0000));
    chk("R3", "first buffer tag", 256'(breq_tag), 0);
    chk("R2", "miss not ready", 256'(lk_ready), 0);
    tick();
    for (int i = 0; i < 5; i++) begin
      ret(1, 0, wdat(b, i)); #1;
      chk("R7", "no second request", 256'(breq_valid), 0);
      chk("R6", "no forward before word", 256'(dec_valid), 0);
      chk("R6", "waiting not ready", 256'(lk_ready), 0);
      tick();
    end
    ret(1, 0, wdat(b, 5)); #1;
    chk("R6", "forward valid", 256'(dec_valid), 1);
    chk("R6", "forward word", 256'(dec_word), 256'(wdat(b, 5)));
    chk("R6", "forward ready", 256'(lk_ready), 1);
    tick();
    look(1, 32'h1000_0008, 1, 0); ret(0, 0, 0); #1;
    chk("R7", "stored word hit", 256'(dec_valid), 1);
    chk("R7", "stored word value", 256'(dec_word), 256'(wdat(b, 2)));
    chk("R7", "pending line no request", 256'(breq_valid), 0);
    tick();
    look(1, 32'h1000_0018, 1, 0); ret(1, 0, wdat(b, 6)); #1;
    chk("R6", "forward on arrival word 6", 256'(dec_word), 256'(wdat(b, 6)));
    chk("R6", "forward ready word 6", 256'(lk_ready), 1);
    tick();
    look(0, 0, 0, 0); ret(1, 0, wdat(b, 7)); #1;
    chk("R8", "no fill before complete", 256'(fill_valid), 0);
    tick();
    ret(0, 0, 0); #1;
    chk("R8", "fill valid", 256'(fill_valid), 1);
    chk("R8", "fill address", 256'(fill_addr), 256'(32'h1000_0000));
    chk("R5", "fill line data", fill_line, exp_line(b));
    tick();
    look(1, 32'h1000_0014, 1, 1); #1;
    chk("R8", "fill is one cycle", 256'(fill_valid), 0);
    chk("R9", "freed line served by cache", 256'(breq_valid), 0);
    tick();
    look(0, 0, 0, 0);
  endtask

  task automatic t_uncacheable();
    logic [31:0] b = 32'hC000_0000;
    logic [31:0] d = 32'hD000_0000;
    look(1, 32'h3000_0000, 0, 0); #1;
    chk("R3", "tag 0 reused", 256'(breq_tag), 0);
    chk("R4", "request uncacheable", 256'(breq_valid), 1);
    tick();
    ret(1, 0, wdat(b, 0)); #1;
    chk("R6", "forward word 0", 256'(dec_word), 256'(wdat(b, 0)));
    tick();
    look(0, 0, 0, 0);
    for (int i = 1; i < 8; i++) begin ret(1, 0, wdat(b, i)); tick(); end
    ret(0, 0, 0); #1;
    chk("R8", "uncacheable not filled", 256'(fill_valid), 0);
    tick();
    cache_en = 0;
    look(1, 32'h3000_0004, 1, 0); #1;
    chk("R9", "cleared buffer misses again", 256'(breq_valid), 1);
    chk("R9", "cleared word not hit", 256'(dec_valid), 0);
    chk("R9", "request address", 256'(breq_addr), 256'(32'h3000_0000));
    tick();
    ret(1, 0, wdat(d, 0)); #1;
    chk("R6", "word 1 not yet", 256'(dec_valid), 0);
    tick();
    ret(1, 0, wdat(d, 1)); #1;
    chk("R6", "forward word 1", 256'(dec_word), 256'(wdat(d, 1)));
    tick();
    look(0, 0, 0, 0);
    for (int i = 2; i < 8; i++) begin ret(1, 0, wdat(d, i)); tick(); end
    ret(0, 0, 0); #1;
    chk("R8", "cache disabled not filled", 256'(fill_valid), 0);
    tick();
    cache_en = 1;
    tick();
  endtask

  task automatic t_two_and_stall();
    logic [31:0] ba = 32'h1100_0000;
    logic [31:0] bb = 32'h2200_0000;
    logic [31:0] bc = 32'h3300_0000;
    look(1, 32'h4000_0000, 1, 0); #1;
    chk("R3", "first miss tag 0", 256'(breq_tag), 0);
    tick();
    ret(1, 0, wdat(ba, 0)); #1;
    chk("R6", "line A word 0", 256'(dec_word), 256'(wdat(ba, 0)));
    tick();
    look(1, 32'h5000_0004, 1, 0); ret(0, 0, 0); #1;
    chk("R3", "second miss requests", 256'(breq_valid), 1);
    chk("R3", "second miss tag 1", 256'(breq_tag), 1);
    chk("R4", "line B address", 256'(breq_addr), 256'(32'h5000_0000));
    tick();
    ret(1, 1, wdat(bb, 0)); #1;
    chk("R6", "line B word 0 not wanted", 256'(dec_valid), 0);
    tick();
    ret(1, 1, wdat(bb, 1)); #1;
    chk("R6", "line B word 1", 256'(dec_word), 256'(wdat(bb, 1)));
    tick();
    look(1, 32'h6000_0000, 1, 0); ret(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10", "stall not ready", 256'(lk_ready), 0);
      chk("R10", "stall no request", 256'(breq_valid), 0);
      tick();
    end
    for (int i = 1; i < 8; i++) begin
      ret(1, 0, wdat(ba, i)); #1;
      chk("R10", "stall while filling", 256'(breq_valid), 0);
      tick();
    end
    ret(0, 0, 0); #1;
    chk("R8", "line A filled", 256'(fill_valid), 1);
    chk("R8", "line A address", 256'(fill_addr), 256'(32'h4000_0000));
    chk("R10", "still stalled in fill cycle", 256'(breq_valid), 0);
    tick();
    #1;
    chk("R10", "stall released", 256'(breq_valid), 1);
    chk("R3", "freed tag 0 reused", 256'(breq_tag), 0);
    chk("R4", "line C address", 256'(breq_addr), 256'(32'h6000_0000));
    tick();
    ret(1, 0, wdat(bc, 0)); #1;
    chk("R6", "line C word 0", 256'(dec_word), 256'(wdat(bc, 0)));
    tick();
    look(0, 0, 0, 0);
    for (int k = 1; k < 8; k++) begin
      if (k >= 2) begin ret(1, 1, wdat(bb, k)); tick(); end
      ret(1, 0, wdat(bc, k)); #1;
      if (k == 7) begin
        chk("R8", "line B filled", 256'(fill_valid), 1);
        chk("R8", "line B address", 256'(fill_addr), 256'(32'h5000_0000));
        chk("R5", "line B interleaved data", fill_line, exp_line(bb));
      end
      tick();
    end
    ret(0, 0, 0); #1;
    chk("R8", "line C filled", 256'(fill_valid), 1);
    chk("R8", "line C address", 256'(fill_addr), 256'(32'h6000_0000));
    chk("R5", "line C interleaved data", fill_line, exp_line(bc));
    tick();
    #1;
    chk("R8", "no fill after", 256'(fill_valid), 0);
    tick();
  endtask

  initial begin
    rst_n = 0; cache_en = 1;
    look(0, 0, 0, 0); ret(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cache_hit();
    t_miss_forward();
    t_uncacheable();
    t_two_and_stall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule